// File: doc/BRIEF.md
# Four-Channel Sample Mean and Noise Monitor

This block watches four parallel streams of signed samples and, over a window whose length is a power of two, works out two figures for one channel at a time. The first is the average sample value. The second is a noise figure: the average distance of each sample from that channel's previous average. Each channel keeps its own pair of 14-bit results. These results can only be read.

Software picks the window length with a 5-bit exponent N, so a window holds 2^(N+1) samples. It then either names one channel to measure, or lets the block visit channels 1 to 4 in turn, one window each. A one-cycle done pulse marks the moment a channel's pair of results is replaced. Register bus decoding sits outside this block, which takes its settings as plain inputs.

Top module: `stat_mon`

## Requirements
- R1: During and right after reset, all eight result fields read zero and `done_o` is low.
- R2: A window ends on its 2^(N+1)-th counted sample. `done_o` is high for exactly the one cycle after the clock edge that takes that sample, and the new results are visible in that same cycle.
- R3: The mean result is the signed sum of the window's samples divided by 2^(N+1), rounded toward minus infinity. It is a 14-bit two's-complement value, sign-extended from the 12-bit sample width.
- R4: The noise result is the sum over the window of |sample − reference| divided by 2^(N+1), rounded down, as an unsigned 14-bit value. The reference is that channel's mean result as it stood when the window began, which is zero after reset.
- R5: In manual mode (`auto_i`=0), `man_sel_i` values 0, 1, 2 and 3 pick channels 1, 2, 3 and 4. Channel k reads sample bits [12k+11:12k] and owns result bits [14k+13:14k], for k=0..3. Only the selected channel's results change at the end of a window.
- R6: In auto mode (`auto_i`=1), windows visit channels 1, 2, 3, 4, 1 and so on back to back. The tour starts at channel 1 whenever computation starts, and `man_sel_i` is ignored.
- R7: A cycle with `smp_valid_i` low is not counted and adds nothing to either sum.
- R8: While `stat_en_i` is low, no window runs. A window cut short this way is thrown away and the results stay as they were. When `stat_en_i` returns, the first cycle only arms the block and its sample is not counted. Counting starts on the next cycle.
- R9: An exponent of 31 is illegal and acts as if the block were disabled. No done pulse occurs and no result changes.
- R10: The exponent, the channel choice and the mode are captured when a window starts. A change made part-way through a window takes effect from the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_en_i | input | 1 | Computation enable |
| win_exp_i | input | 5 | Window exponent N, window = 2^(N+1) samples |
| man_sel_i | input | 2 | Manual channel choice (0..3 for channels 1..4) |
| auto_i | input | 1 | 1 = round-robin over all channels |
| smp_valid_i | input | 1 | Samples on `smp_i` are valid this cycle |
| smp_i | input | 48 | Four signed 12-bit samples, channel 1 in the low bits |
| mean_o | output | 56 | Four 14-bit mean results, channel 1 in the low bits |
| noise_o | output | 56 | Four 14-bit noise results, channel 1 in the low bits |
| done_o | output | 1 | One-cycle pulse when a channel's results update |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A miscounted window moves `done_o` away from the cycle right after the last sample edge, so it is caught at the very first window end.
- A wrong latched channel or a wrong sequencer step shows up as a result appearing under the wrong channel. The other channels are compared at every done pulse, so this is caught at the first faulty window.
- A wrong reference for the noise figure stays hidden until a channel is measured a second time, when its noise value comes out wrong. The bench therefore measures each channel repeatedly and mixes negative sums, to catch faults in rounding toward minus infinity.

// File: rtl/stat_mon_pkg.sv
// Shared types for the sample mean and noise monitor.
package stat_mon_pkg;
    // Run state of the window engine.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;
endpackage

// File: rtl/stat_win_cfg.sv
// Window configuration latch and channel sequencer.
// Captures exponent, mode and channel when a window starts. In auto mode it
// steps to the next channel at each window end, wrapping after the last one.
// Assumes N_CH is a power of two.
module stat_win_cfg #(
    parameter int N_CH  = 4,
    parameter int EXP_W = 5,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wrap_i,
    input  logic             auto_i,
    input  logic [CH_W-1:0]  sel_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [CH_W-1:0]  ch_o,
    output logic [EXP_W-1:0] exp_o
);
    logic [CH_W-1:0]  ch_q;
    logic [EXP_W-1:0] exp_q;
    logic             auto_q;
    logic [CH_W-1:0]  ch_next;

    // Next channel in round-robin order.
    always_comb begin
        if (ch_q == CH_W'(N_CH - 1)) ch_next = '0;
        else                         ch_next = ch_q + CH_W'(1);
    end

    // Capture window settings at start or at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            exp_q  <= '0;
            auto_q <= 1'b0;
        end else if (start_i || wrap_i) begin
            exp_q  <= exp_i;
            auto_q <= auto_i;
            if (auto_i) ch_q <= (wrap_i && auto_q) ? ch_next : '0;
            else        ch_q <= sel_i;
        end
    end

    assign ch_o  = ch_q;
    assign exp_o = exp_q;
endmodule

// File: rtl/stat_win_ctr.sv
// Window sample counter.
// Counts valid samples and flags the last one of a 2^(exp+1) window.
// Assumes exp_i never exceeds CNT_W-1.
module stat_win_ctr #(
    parameter int CNT_W = 31,
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [7:0]       shamt;

    // Terminal count is 2^(exp+1)-1, formed from an all-ones vector.
    always_comb begin
        shamt = 8'(CNT_W - 1) - 8'(exp_i);
        limit = {CNT_W{1'b1}} >> shamt;
    end

    assign last_o = (cnt_q == limit);

    // Sample counter; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/stat_accum.sv
// Mean and absolute-deviation accumulators for the channel being measured.
// Presents the final window figures with the current sample already added,
// so results can be latched on the edge of the last sample.
// Assumes ACC_W holds DATA_W-wide sums over 2^(MAX_EXP+1) samples.
module stat_accum #(
    parameter int DATA_W = 12,
    parameter int RES_W  = 14,
    parameter int EXP_W  = 5,
    parameter int ACC_W  = 46
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     add_i,
    input  logic                     end_i,
    input  logic signed [DATA_W-1:0] smp_i,
    input  logic signed [RES_W-1:0]  ref_i,
    input  logic [EXP_W-1:0]         exp_i,
    output logic signed [RES_W-1:0]  mean_o,
    output logic [RES_W-1:0]         noise_o
);
    logic signed [ACC_W-1:0] msum_q, msum_nx;
    logic [ACC_W-1:0]        nsum_q, nsum_nx;
    logic signed [RES_W:0]   dev;
    logic [RES_W:0]          adev;
    logic [EXP_W:0]          sh;

    // Deviation from reference and running sums including this sample.
    always_comb begin
        dev     = (RES_W+1)'(smp_i) - (RES_W+1)'(ref_i);
        adev    = dev[RES_W] ? (RES_W+1)'(-dev) : (RES_W+1)'(dev);
        msum_nx = msum_q + ACC_W'(smp_i);
        nsum_nx = nsum_q + ACC_W'(adev);
        sh      = {1'b0, exp_i} + (EXP_W+1)'(1);
        mean_o  = RES_W'(msum_nx >>> sh);
        noise_o = RES_W'(nsum_nx >> sh);
    end

    // Accumulate valid samples; clear at idle and after window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            msum_q <= '0;
            nsum_q <= '0;
        end else if (add_i) begin
            msum_q <= end_i ? '0 : msum_nx;
            nsum_q <= end_i ? '0 : nsum_nx;
        end
    end
endmodule

// File: rtl/stat_mon.sv
// Four-channel sample mean and noise monitor, top level.
// Runs windows of 2^(N+1) valid samples on one channel at a time, manual or
// round-robin, and latches per-channel mean and noise at each window end.
// Assumes DATA_W < RES_W so deviations and means fit the result width.
module stat_mon
    import stat_mon_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int DATA_W  = 12,
    parameter int RES_W   = 14,
    parameter int EXP_W   = 5,
    parameter int MAX_EXP = 30,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CNT_W  = MAX_EXP + 1,
    localparam int ACC_W  = RES_W + 2 + MAX_EXP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stat_en_i,
    input  logic [EXP_W-1:0]         win_exp_i,
    input  logic [CH_W-1:0]          man_sel_i,
    input  logic                     auto_i,
    input  logic                     smp_valid_i,
    input  logic [N_CH*DATA_W-1:0]   smp_i,
    output logic [N_CH*RES_W-1:0]    mean_o,
    output logic [N_CH*RES_W-1:0]    noise_o,
    output logic                     done_o
);
    run_st_e                  st_q;
    logic                     cfg_ok;
    logic                     start;
    logic                     step;
    logic                     last;
    logic                     win_end;
    logic [CH_W-1:0]          ch;
    logic [EXP_W-1:0]         exp_q;
    logic signed [DATA_W-1:0] lane [N_CH];
    logic signed [RES_W-1:0]  mean_q [N_CH];
    logic [RES_W-1:0]         noise_q [N_CH];
    logic signed [RES_W-1:0]  acc_mean;
    logic [RES_W-1:0]         acc_noise;
    logic                     done_q;

    // Settings are usable when enabled with a legal exponent.
    assign cfg_ok  = stat_en_i && (int'(win_exp_i) <= MAX_EXP);
    assign start   = (st_q == ST_IDLE) && cfg_ok;
    assign step    = (st_q == ST_RUN) && cfg_ok && smp_valid_i;
    assign win_end = step && last;

    // Run state: arm on first legal enable, drop out when it goes away.
    always_ff @(posedge clk) begin
        if (!rst_n)       st_q <= ST_IDLE;
        else if (!cfg_ok) st_q <= ST_IDLE;
        else              st_q <= ST_RUN;
    end

    stat_win_cfg #(
        .N_CH  (N_CH),
        .EXP_W (EXP_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .wrap_i  (win_end),
        .auto_i  (auto_i),
        .sel_i   (man_sel_i),
        .exp_i   (win_exp_i),
        .ch_o    (ch),
        .exp_o   (exp_q)
    );

    stat_win_ctr #(
        .CNT_W (CNT_W),
        .EXP_W (EXP_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!cfg_ok || start || win_end),
        .inc_i  (step),
        .exp_i  (exp_q),
        .last_o (last)
    );

    stat_accum #(
        .DATA_W (DATA_W),
        .RES_W  (RES_W),
        .EXP_W  (EXP_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!cfg_ok || start),
        .add_i   (step),
        .end_i   (last),
        .smp_i   (lane[ch]),
        .ref_i   (mean_q[ch]),
        .exp_i   (exp_q),
        .mean_o  (acc_mean),
        .noise_o (acc_noise)
    );

    // Per-channel lanes and result registers.
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        assign lane[k] = smp_i[k*DATA_W +: DATA_W];

        // Replace this channel's pair when its window ends.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mean_q[k]  <= '0;
                noise_q[k] <= '0;
            end else if (win_end && (ch == CH_W'(k))) begin
                mean_q[k]  <= acc_mean;
                noise_q[k] <= acc_noise;
            end
        end

        assign mean_o[k*RES_W +: RES_W]  = mean_q[k];
        assign noise_o[k*RES_W +: RES_W] = noise_q[k];
    end

    // Done pulse aligned with the result update.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= win_end;
    end

    assign done_o = done_q;
endmodule

// File: rtl/stat_mon_chk.sv
// Property checker for stat_mon, attached by bind.
// Watches the result buses and done pulse against the enable and sample inputs.
module stat_mon_chk #(
    parameter int N_CH    = 4,
    parameter int RES_W   = 14,
    parameter int EXP_W   = 5,
    parameter int MAX_EXP = 30
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stat_en_i,
    input logic [EXP_W-1:0]      win_exp_i,
    input logic                  smp_valid_i,
    input logic [N_CH*RES_W-1:0] mean_o,
    input logic [N_CH*RES_W-1:0] noise_o,
    input logic                  done_o
);
    logic [N_CH*RES_W-1:0] mean_prev, noise_prev;
    logic [N_CH-1:0]       chg;

    // Copy of the result buses one cycle back.
    always_ff @(posedge clk) begin
        mean_prev  <= mean_o;
        noise_prev <= noise_o;
    end

    // Per-channel change flags.
    for (genvar k = 0; k < N_CH; k++) begin : g_chg
        assign chg[k] = (mean_o[k*RES_W +: RES_W] != mean_prev[k*RES_W +: RES_W]) ||
                        (noise_o[k*RES_W +: RES_W] != noise_prev[k*RES_W +: RES_W]);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mean_o == '0) && (noise_o == '0) && !done_o);

    // R2
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    results_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (chg != '0) |-> done_o);

    // R5
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    // R7
    done_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(smp_valid_i));

    // R8
    done_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(stat_en_i));

    // R9
    legal_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(int'(win_exp_i) <= MAX_EXP));
endmodule

bind stat_mon stat_mon_chk #(
    .N_CH    (N_CH),
    .RES_W   (RES_W),
    .EXP_W   (EXP_W),
    .MAX_EXP (MAX_EXP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_en_i   (stat_en_i),
    .win_exp_i   (win_exp_i),
    .smp_valid_i (smp_valid_i),
    .mean_o      (mean_o),
    .noise_o     (noise_o),
    .done_o      (done_o)
);

// File: tb/stat_mon_tb.sv
// Self-checking bench: sweeps channels, exponents, modes and interruptions,
// with expected figures computed arithmetically from the requirements.
module stat_mon_tb;
    localparam int NC = 4;
    localparam int DW = 12;
    localparam int RW = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [4:0]       wexp = '0;
    logic [1:0]       sel = '0;
    logic             autom = 1'b0;
    logic             valid = 1'b0;
    logic [NC*DW-1:0] smp = '0;
    logic [NC*RW-1:0] mean_o, noise_o;
    logic             done_o;

    int n_chk = 0;
    int n_err = 0;
    int e_mean [NC];
    int e_noise [NC];

    always #4 clk = ~clk;

    stat_mon u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_en_i   (en),
        .win_exp_i   (wexp),
        .man_sel_i   (sel),
        .auto_i      (autom),
        .smp_valid_i (valid),
        .smp_i       (smp),
        .mean_o      (mean_o),
        .noise_o     (noise_o),
        .done_o      (done_o)
    );

    function automatic int gen(int pat, int i);
        int v;
        case (pat % 6)
            0:       v = (i % 2 == 1) ? 2047 : -2048;
            1:       v = -2048;
            2:       v = 2047;
            3:       v = i * 37 - 100 - pat;
            4:       v = i * i * 13 + pat * 71;
            default: v = (i + pat) * 2654435 + 977 * pat;
        endcase
        v = v & 4095;
        if (v >= 2048) v = v - 4096;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rd_mean(int k);
        return int'($signed(mean_o[k*RW +: RW]));
    endfunction

    function automatic int rd_noise(int k);
        return int'(noise_o[k*RW +: RW]);
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < NC; k++) begin
            chk(rd_mean(k) == e_mean[k], req, rd_mean(k), e_mean[k]);
            chk(rd_noise(k) == e_noise[k], req, rd_noise(k), e_noise[k]);
        end
    endtask

    task automatic drive(input int ch, input int pat, input int i, input bit v);
        valid = v;
        for (int k = 0; k < NC; k++)
            smp[k*DW +: DW] = (k == ch && v) ? DW'(gen(pat, i)) : DW'(gen(pat + 7 + k, i + 3));
    endtask

    // Disable for a cycle, load settings, enable, let the arming cycle pass.
    task automatic restart(input int s, input int n, input bit a);
        @(negedge clk);
        en = 1'b0;
        valid = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R2 done single cycle", done_o, 0);
        sel = 2'(s);
        wexp = 5'(n);
        autom = a;
        en = 1'b1;
        @(negedge clk);
    endtask

    // Feed one whole window for channel ch and check results at its end.
    task automatic feed(input int ch, input int n, input int pat, input bit gaps,
                        input bit mid, input int msel, input int mexp);
        longint sum = 0;
        longint nsum = 0;
        int     len = 1 << (n + 1);
        int     rf = e_mean[ch];
        int     v;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                drive(ch, pat + 1, i, 1'b0); // R7 unused cycle
                @(negedge clk);
            end
            drive(ch, pat, i, 1'b1);
            v = gen(pat, i);
            sum += v;
            nsum += (v >= rf) ? (v - rf) : (rf - v);
            if (i == len - 1) chk(done_o == 1'b0, "R2 early done", done_o, 0);
            @(negedge clk);
            if (mid && i == 0) begin
                sel = 2'(msel); // R10 mid-window change
                wexp = 5'(mexp);
            end
        end
        valid = 1'b0;
        chk(done_o == 1'b1, "R2 done at end", done_o, 1);
        e_mean[ch] = int'(sum >>> (n + 1));
        e_noise[ch] = int'(nsum >>> (n + 1));
        chk(rd_mean(ch) == e_mean[ch], "R3 mean", rd_mean(ch), e_mean[ch]);
        chk(rd_noise(ch) == e_noise[ch], "R4 noise", rd_noise(ch), e_noise[ch]);
        check_all("R5 other channels held");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit seen;
        for (int k = 0; k < NC; k++) begin
            e_mean[k] = 0;
            e_noise[k] = 0;
        end
        repeat (4) @(negedge clk);
        check_all("R1 reset");
        chk(done_o == 1'b0, "R1 reset done", done_o, 0);
        rst_n = 1'b1;

        // R5 R3 R4: manual sweep over every channel and small exponents
        for (int s = 0; s < NC; s++)
            for (int n = 0; n < 4; n++) begin
                restart(s, n, 1'b0);
                feed(s, n, s * 4 + n, n == 2, 1'b0, 0, 0);
            end
        // Larger windows, negative sums
        restart(1, 6, 1'b0);
        feed(1, 6, 3, 1'b1, 1'b0, 0, 0);
        restart(3, 9, 1'b0);
        feed(3, 9, 5, 1'b0, 1'b0, 0, 0);

        // R2: back-to-back windows on one channel reuse the new reference
        restart(2, 1, 1'b0);
        feed(2, 1, 1, 1'b0, 1'b0, 0, 0);
        feed(2, 1, 2, 1'b0, 1'b0, 0, 0);

        // R10: settings changed mid-window apply from the next window
        restart(1, 1, 1'b0);
        feed(1, 1, 9, 1'b0, 1'b1, 3, 0);
        feed(3, 0, 10, 1'b0, 1'b0, 0, 0);

        // R6: auto tour starting at channel 1, selection ignored
        restart(2, 0, 1'b1);
        for (int w = 0; w < 6; w++) feed(w % NC, 0, 11 + w, w == 3, 1'b0, 0, 0);
        restart(3, 1, 1'b1);
        for (int w = 0; w < 5; w++) feed(w % NC, 1, 20 + w, 1'b0, 1'b0, 0, 0);

        // R8: partial window discarded, arming cycle sample ignored
        restart(0, 1, 1'b0);
        for (int i = 0; i < 2; i++) begin
            drive(0, 1, i, 1'b1);
            @(negedge clk);
        end
        en = 1'b0;
        valid = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R8 no done when disabled", done_o, 0);
        check_all("R8 results held");
        en = 1'b1;
        drive(0, 2, 0, 1'b1);
        @(negedge clk);
        feed(0, 1, 4, 1'b0, 1'b0, 0, 0);

        // R9: illegal exponent behaves as disabled
        restart(2, 31, 1'b0);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            drive(2, 3, i, 1'b1);
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        valid = 1'b0;
        chk(seen == 1'b0, "R9 no done", seen, 0);
        check_all("R9 results held");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule